// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block decides whether the address phase of an I2C transfer selects the local target. An external shift stage turns the serial line into bytes and reports bus events (start or repeated start, stop, and each completed byte). The recognizer looks only at the first byte after a start, and in 10-bit mode also at the byte that follows it. It reports a hit as a single-cycle pulse. With the pulse it gives which of its two own addresses was hit and the direction bit of the transfer.

Two configuration words hold the addresses. The primary word carries a 10-bit address field and an addressing-mode bit. The secondary word carries an optional extra 7-bit address and its enable. In 7-bit mode either address can be hit. In 10-bit mode only the primary address is used: a write header followed by the low address byte selects the device. After such a write, a repeated start followed by the read header selects the device again without a second address byte.

Top module: `tgt_addr_recognizer`

## Requirements
- R1: After reset both configuration words read as 0x0000, `hit_pulse` is 0 and `hit_dir` is 0.
- R2: Selector 0 addresses the primary word: bit 15 is the mode (1 = 10-bit), bits 9:0 are the address, and bits 14:10 read as 0. Selector 1 addresses the secondary word: bits 7:1 are the extra 7-bit address, bit 0 is its enable, and bits 15:8 read as 0.
- R3: In 7-bit mode, the first byte after a start hits the primary address when byte bits 7:1 equal primary bits 7:1. Primary bits 9:8 and bit 0 have no effect.
- R4: In 7-bit mode, the extra address is hit (`hit_sel` = 1) only when its enable is 1 and byte bits 7:1 equal it. When both addresses are equal the primary one is reported (`hit_sel` = 0).
- R5: In 10-bit mode, a first byte of 11110 followed by primary bits 9:8 and a 0 direction bit, then a second byte equal to primary bits 7:0, gives a hit with `hit_sel` = 0 and `hit_dir` = 0. No pulse is given on the header byte.
- R6: In 10-bit mode the extra address is never compared, and a single byte never gives a hit unless it is a read header as in R7.
- R7: After a 10-bit write hit, a repeated start followed by the header with direction bit 1 gives a hit with `hit_dir` = 1 on that byte. Without that earlier hit, the read header gives no hit.
- R8: A stop clears the pending header state and the earlier-write memory. A new start abandons a header that is waiting for its low byte. No hit follows a stop until a new start.
- R9: `hit_pulse` is high for exactly one cycle, in the cycle after the clock edge that took the deciding byte. `hit_sel` and `hit_dir` keep their values until the next hit.
- R10: Bytes after the address phase, such as data bytes, never give a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word chosen by `cfg_sel` |
| cfg_sel | input | 1 | 0 = primary word, 1 = secondary word |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read-back of the chosen word, reserved bits zero |
| bus_start | input | 1 | Start or repeated start seen (one cycle) |
| bus_stop | input | 1 | Stop seen (one cycle) |
| byte_vld | input | 1 | A received byte is on `byte_in` (one cycle) |
| byte_in | input | 8 | Received byte, MSB first as on the wire |
| hit_pulse | output | 1 | One-cycle address-hit pulse |
| hit_sel | output | 1 | 0 = primary address hit, 1 = extra address hit |
| hit_dir | output | 1 | Direction bit of the last hit (1 = read) |

## Verification
On every cycle, the assertions check the following: the hit pulse never lasts two cycles and always follows an accepted byte; the direction and selector stay steady between hits; no hit comes right after a stop; and an extra-address hit needs 7-bit mode with the enable set. Only the bench scenarios can show which byte values give a hit. The bench sweeps every first byte under several address setups, every header byte and every low byte in 10-bit mode, and the repeated-start read sequence with and without the earlier write.

// File: rtl/tar_pkg.sv
// Shared types and constants of the target address recognizer.
// Assumes a standard 8-bit I2C address byte with the direction in bit 0.
package tar_pkg;
    localparam int TAG_W = 5;
    localparam logic [TAG_W-1:0] HDR_TAG = 5'b11110;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no transfer in progress
        ST_FIRST = 2'd1,   // waiting for first byte after a start
        ST_LOW   = 2'd2,   // 10-bit header seen, waiting for low byte
        ST_DATA  = 2'd3    // address phase over, ignore bytes
    } tar_state_t;
endpackage

// File: rtl/tar_regs.sv
// Configuration words of the recognizer.
// Holds the primary address with its mode bit and the extra 7-bit
// address with its enable. Reserved positions are not stored, so
// they read as zero. Assumes a single-cycle write strobe.
module tar_regs #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              mode10,
    output logic [ADDR_W-1:0] own1,
    output logic [BYTE_W-2:0] own2,
    output logic              own2_en
);
    localparam int MODE_BIT = REG_W - 1;
    localparam int GAP1_W   = REG_W - 1 - ADDR_W;
    localparam int GAP2_W   = REG_W - BYTE_W;

    logic unused_bits;

    // Store the written fields; reserved bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode10  <= 1'b0;
            own1    <= '0;
            own2    <= '0;
            own2_en <= 1'b0;
        end else if (wr_en) begin
            if (!sel) begin
                mode10 <= wdata[MODE_BIT];
                own1   <= wdata[ADDR_W-1:0];
            end else begin
                own2    <= wdata[BYTE_W-1:1];
                own2_en <= wdata[0];
            end
        end
    end

    // Read-back mux with reserved positions tied to zero.
    always_comb begin
        if (!sel) begin
            rdata = {mode10, {GAP1_W{1'b0}}, own1};
        end else begin
            rdata = {{GAP2_W{1'b0}}, own2, own2_en};
        end
    end

    assign unused_bits = ^{wdata[REG_W-2:ADDR_W], wdata[REG_W-1:BYTE_W]};
endmodule

// File: rtl/tar_cmp.sv
// Byte comparators of the recognizer (purely combinational).
// Produces the candidate hits for the current byte; the sequencer
// decides which one counts in its present state.
// Assumes ADDR_W - BYTE_W address bits travel in the 10-bit header.
module tar_cmp
    import tar_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              mode10,
    input  logic [ADDR_W-1:0] own1,
    input  logic [BYTE_W-2:0] own2,
    input  logic              own2_en,
    output logic              hit_a7,
    output logic              hit_b7,
    output logic              hdr_ok,
    output logic              low_ok
);
    localparam int HI_W = ADDR_W - BYTE_W;

    // 7-bit compares ignore the direction bit and the upper address bits.
    always_comb begin
        hit_a7 = !mode10 && (byte_in[BYTE_W-1:1] == own1[BYTE_W-1:1]);
        hit_b7 = !mode10 && own2_en && (byte_in[BYTE_W-1:1] == own2);
    end

    // 10-bit header and low-byte compares, gated by the mode.
    always_comb begin
        hdr_ok = mode10
              && (byte_in[BYTE_W-1 -: TAG_W] == HDR_TAG)
              && (byte_in[HI_W:1] == own1[ADDR_W-1:BYTE_W]);
        low_ok = mode10 && (byte_in == own1[BYTE_W-1:0]);
    end
endmodule

// File: rtl/tar_seq.sv
// Address-phase sequencer.
// Tracks where the bus is in the address phase, runs the 10-bit
// header sequence, remembers a completed 10-bit write for the
// repeated-start read, and registers the hit outputs.
// Assumes start, stop and byte strobes are single-cycle; a start
// in the same cycle as a byte wins and the byte is dropped.
module tar_seq
    import tar_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              hit_a7,
    input  logic              hit_b7,
    input  logic              hdr_ok,
    input  logic              low_ok,
    output logic              hit_pulse,
    output logic              hit_sel,
    output logic              hit_dir
);
    tar_state_t st;
    logic       wr_done;   // a 10-bit write hit happened since the last stop
    logic       dir_bit;

    assign dir_bit = byte_in[0];

    // State, memory of the 10-bit write, and registered hit outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            wr_done   <= 1'b0;
            hit_pulse <= 1'b0;
            hit_sel   <= 1'b0;
            hit_dir   <= 1'b0;
        end else begin
            hit_pulse <= 1'b0;
            if (bus_start || bus_stop) begin
                st <= bus_start ? ST_FIRST : ST_IDLE;
                if (bus_stop) begin
                    wr_done <= 1'b0;
                end
            end else if (byte_vld) begin
                case (st)
                    ST_FIRST: begin
                        st <= ST_DATA;
                        if (hit_a7 || hit_b7) begin
                            hit_pulse <= 1'b1;
                            hit_sel   <= !hit_a7;
                            hit_dir   <= dir_bit;
                            wr_done   <= 1'b0;
                        end else if (hdr_ok && !dir_bit) begin
                            st      <= ST_LOW;
                            wr_done <= 1'b0;
                        end else if (hdr_ok && wr_done) begin
                            hit_pulse <= 1'b1;
                            hit_sel   <= 1'b0;
                            hit_dir   <= 1'b1;
                        end else begin
                            wr_done <= 1'b0;
                        end
                    end
                    ST_LOW: begin
                        st <= ST_DATA;
                        if (low_ok) begin
                            hit_pulse <= 1'b1;
                            hit_sel   <= 1'b0;
                            hit_dir   <= 1'b0;
                            wr_done   <= 1'b1;
                        end
                    end
                    default: begin
                        st <= st;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tgt_addr_recognizer.sv
// Top of the I2C target address recognizer.
// Connects configuration words, byte comparators and the sequencer.
// Assumes bus events and bytes come from an outside shift stage in
// the same clock domain.
module tgt_addr_recognizer #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              hit_pulse,
    output logic              hit_sel,
    output logic              hit_dir
);
    logic              mode10;
    logic [ADDR_W-1:0] own1;
    logic [BYTE_W-2:0] own2;
    logic              own2_en;
    logic              hit_a7, hit_b7, hdr_ok, low_ok;

    tar_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .mode10  (mode10),
        .own1    (own1),
        .own2    (own2),
        .own2_en (own2_en)
    );

    tar_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
        .byte_in (byte_in),
        .mode10  (mode10),
        .own1    (own1),
        .own2    (own2),
        .own2_en (own2_en),
        .hit_a7  (hit_a7),
        .hit_b7  (hit_b7),
        .hdr_ok  (hdr_ok),
        .low_ok  (low_ok)
    );

    tar_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .hit_a7    (hit_a7),
        .hit_b7    (hit_b7),
        .hdr_ok    (hdr_ok),
        .low_ok    (low_ok),
        .hit_pulse (hit_pulse),
        .hit_sel   (hit_sel),
        .hit_dir   (hit_dir)
    );
endmodule

// File: rtl/tar_checker.sv
// Protocol checker for the recognizer, attached with bind.
module tar_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_stop,
    input logic byte_vld,
    input logic hit_pulse,
    input logic hit_sel,
    input logic hit_dir,
    input logic cfg_mode10,
    input logic cfg_own2_en
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |=> !hit_pulse);  // R9
    AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> $past(byte_vld));  // R9
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_pulse |-> ($stable(hit_dir) && $stable(hit_sel)));  // R9
    AST_QUIET_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !hit_pulse);  // R8
    AST_EXTRA_ONLY_7BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pulse && hit_sel) |-> ($past(cfg_own2_en) && !$past(cfg_mode10)));  // R6
endmodule

bind tgt_addr_recognizer tar_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_stop    (bus_stop),
    .byte_vld    (byte_vld),
    .hit_pulse   (hit_pulse),
    .hit_sel     (hit_sel),
    .hit_dir     (hit_dir),
    .cfg_mode10  (mode10),
    .cfg_own2_en (own2_en)
);

// File: tb/sim_tgt_addr_recognizer.sv
`timescale 1ns/1ps
module sim_tgt_addr_recognizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        hit_pulse, hit_sel, hit_dir;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tgt_addr_recognizer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .hit_pulse(hit_pulse), .hit_sel(hit_sel), .hit_dir(hit_dir)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_cfg(input string req, input logic sel, input logic [15:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        chk(req, int'(cfg_rdata), int'(exp));
    endtask

    task automatic ev_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic p, output logic s, output logic d);
        @(negedge clk); byte_vld = 1'b1; byte_in = b;
        @(negedge clk); byte_vld = 1'b0;
        p = hit_pulse; s = hit_sel; d = hit_dir;
    endtask

    // 7-bit sweep over every first byte for one configuration
    task automatic sweep7(input logic [15:0] w1, input logic [15:0] w2);
        logic p, s, d, p2, s2, d2;
        logic [6:0] a1, a2;
        logic en;
        wr_cfg(1'b0, w1);
        wr_cfg(1'b1, w2);
        a1 = w1[7:1]; a2 = w2[7:1]; en = w2[0];
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            logic e1, e2;
            bb = 8'(b);
            e1 = (bb[7:1] == a1);
            e2 = en && (bb[7:1] == a2);
            ev_start();
            send(bb, p, s, d);
            chk("R3/R4 hit", int'(p), int'(e1 || e2));
            if (e1 || e2) begin
                chk("R4 sel", int'(s), int'(!e1));
                chk("R9 dir", int'(d), int'(bb[0]));
            end
            send(bb, p2, s2, d2);
            chk("R10 data byte", int'(p2), 0);
            if (e1 || e2) chk("R9 dir held", int'(d2), int'(bb[0]));
            ev_stop();
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic p, s, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_cfg("R1 word0", 1'b0, 16'h0000);
        rd_cfg("R1 word1", 1'b1, 16'h0000);
        chk("R1 pulse", int'(hit_pulse), 0);
        chk("R1 dir", int'(hit_dir), 0);
        // R2 reserved bits
        wr_cfg(1'b0, 16'hFFFF);
        rd_cfg("R2 word0", 1'b0, 16'h83FF);
        wr_cfg(1'b1, 16'hFFFF);
        rd_cfg("R2 word1", 1'b1, 16'h00FF);
        // R3/R4 sweeps in 7-bit mode (upper bits and bit 0 set to show they are ignored)
        sweep7(16'h036B, {8'h00, 7'h52, 1'b0});
        sweep7(16'h036B, {8'h00, 7'h52, 1'b1});
        sweep7(16'h016A, {8'h00, 7'h35, 1'b1});  // equal addresses: primary wins

        // 10-bit: primary 0x2C6, extra enabled with 7-bit value matching the header
        wr_cfg(1'b0, 16'h8000 | 16'h02C6);
        wr_cfg(1'b1, {8'h00, 7'h7A, 1'b1});
        for (int h = 0; h < 256; h++) begin
            logic [7:0] hb;
            hb = 8'(h);
            ev_start();
            send(hb, p, s, d);
            chk("R6 single byte", int'(p), 0);
            send(8'hC6, p, s, d);
            chk("R5 header sweep", int'(p), int'(hb == 8'hF4));
            if (hb == 8'hF4) begin
                chk("R5 sel", int'(s), 0);
                chk("R5 dir", int'(d), 0);
            end
            ev_stop();
        end
        for (int l = 0; l < 256; l++) begin
            logic [7:0] lb;
            lb = 8'(l);
            ev_start();
            send(8'hF4, p, s, d);
            send(lb, p, s, d);
            chk("R5 low sweep", int'(p), int'(lb == 8'hC6));
            ev_stop();
        end

        // R7 repeated-start read
        ev_start();
        send(8'hF4, p, s, d);
        send(8'hC6, p, s, d);
        chk("R5 write hit", int'(p), 1);
        ev_start();
        send(8'hF5, p, s, d);
        chk("R7 read hit", int'(p), 1);
        chk("R7 read dir", int'(d), 1);
        chk("R7 read sel", int'(s), 0);
        ev_start();
        send(8'hF7, p, s, d);
        chk("R7 wrong header", int'(p), 0);
        ev_stop();
        ev_start();
        send(8'hF5, p, s, d);
        chk("R7 read without write", int'(p), 0);
        // R8 stop clears write memory
        send(8'hC6, p, s, d);
        ev_stop();
        ev_start();
        send(8'hF4, p, s, d);
        send(8'hC6, p, s, d);
        chk("R5 write hit again", int'(p), 1);
        ev_stop();
        ev_start();
        send(8'hF5, p, s, d);
        chk("R8 stop clears memory", int'(p), 0);
        ev_stop();
        // R8 start abandons header
        ev_start();
        send(8'hF4, p, s, d);
        ev_start();
        send(8'hC6, p, s, d);
        chk("R8 start abandons header", int'(p), 0);
        // R8 stop abandons header
        ev_start();
        send(8'hF4, p, s, d);
        ev_stop();
        send(8'hC6, p, s, d);
        chk("R8 stop abandons header", int'(p), 0);
        // R9 pulse lasts one cycle
        ev_start();
        send(8'hF4, p, s, d);
        send(8'hC6, p, s, d);
        chk("R9 pulse", int'(p), 1);
        @(negedge clk);
        chk("R9 pulse one cycle", int'(hit_pulse), 0);
        ev_stop();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule